// File: doc/BRIEF.md
# Dual-Channel Multiplexed Sample Demultiplexer

This block receives the shared 8-bit parallel output of a dual-channel pipelined converter. The converter interleaves its two channels on one bus at double data rate. A channel A word is launched after each rising edge of the converter clock, and a channel B word after each falling edge. A channel-indicator line marks which channel the bus carries: high for channel A, low for channel B. The block runs entirely on a faster system clock. It oversamples the converter clock, the bus and the indicator through a synchronizer. It then takes each word a fixed number of system cycles after the matching converter edge, so the capture falls well inside the window in which the bus is stable.

Captured words are paired. A channel A word is joined with the channel B word that arrives half a converter cycle later. Both words were sampled at the same instant, but channel B reaches the bus half a cycle later than channel A (5.5 against 5 converter cycles). Each completed pair is presented with one single-cycle valid pulse. The pair also carries a tag giving the converter sample instant it belongs to. The tag is derived from a count of rising edges minus the channel A latency.

The converter emits offset-binary codes, in which 0x80 is mid-scale. A mode input either passes these codes through or converts them to two's complement. An indicator level that does not match the edge it was captured on sets a sticky misalignment flag. The block then discards any half-built pair and restarts pairing at the next correct rising edge.

Top module: `dual_sample_demux`

## Requirements
- R1: While reset is asserted and on leaving it, pair_valid_o and misalign_o are low and pair_a_o, pair_b_o and pair_tag_o are zero.
- R2: Each pair_valid_o pulse lasts one system cycle. It presents, on pair_a_o, the word captured after a converter rising edge with chan_a_i high. On pair_b_o it presents the word captured after the next falling edge with chan_a_i low. Exactly one pulse is produced per such pair, in order.
- R3: Rising converter edges are counted from 0 after reset. This count includes rising edges that carry a bad indicator. The pair whose A word follows rising edge n carries pair_tag_o = (n - 5) mod 2^IDX_W.
- R4: With twos_comp_i = 0, output words equal the bus codes unchanged (offset binary; 0x80 stays 0x80).
- R5: With twos_comp_i = 1, each output word is the bus code with bit 7 inverted: 0x80 becomes 0x00, 0x00 becomes 0x80, 0xFF becomes 0x7F and 0x7F becomes 0xFF.
- R6: A rising-edge capture with chan_a_i low sets misalign_o. No pair is produced for that converter cycle, and pairing resumes with the next rising edge whose indicator is high.
- R7: A falling-edge capture with chan_a_i high sets misalign_o and discards the held channel A word, so no pair is produced for that cycle.
- R8: Once set, misalign_o stays high through later correctly aligned traffic until reset.
- R9: The bus and indicator are captured CAP_DELAY system cycles after the synchronized converter edge is seen. Words that change a few nanoseconds after each converter edge are therefore taken at their settled value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_clk_i | input | 1 | Copy of the converter sample clock |
| conv_bus_i | input | 8 | Shared converter data bus, bit 7 most significant |
| chan_a_i | input | 1 | Channel indicator: 1 for channel A word, 0 for channel B word |
| twos_comp_i | input | 1 | Output format: 0 offset binary, 1 two's complement |
| pair_valid_o | output | 1 | One-cycle pulse when a new pair is presented |
| pair_a_o | output | 8 | Channel A word of the pair |
| pair_b_o | output | 8 | Channel B word of the pair |
| pair_tag_o | output | IDX_W | Sample-instant index of the pair |
| misalign_o | output | 1 | Sticky indicator-mismatch flag |

## Verification
The bench models the converter bus with its half-cycle skew and streams long runs of random A and B words, alternating in both output formats. A swapped pair or a lost pair shows up as a word or tag mismatch, which this traffic exposes. Directed words 0x00, 0x7F, 0x80 and 0xFF separate passthrough from MSB inversion and from other mappings. Cycles with a wrong indicator on the rising edge, and separately on the falling edge, show whether the pair is dropped, whether the flag sets and stays, and whether the tag sequence keeps counting across the gap.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    localparam int WORD_W = 8;

    typedef logic [WORD_W-1:0] word_t;

    // One capture event handed from the edge capture stage to the pairing stage
    typedef struct packed {
        logic  fire;   // single-cycle capture strobe
        logic  rise;   // 1: word followed a rising edge, 0: a falling edge
        logic  ind;    // channel indicator level at capture
        word_t word;   // captured bus value
    } capture_t;

    typedef enum logic {
        ST_WAIT_A = 1'b0,
        ST_HOLD_A = 1'b1
    } pair_st_e;

    // Offset binary to two's complement is an inversion of the top bit
    function automatic word_t fmt_word(input word_t code, input logic twos);
        word_t r;
        r = code;
        r[WORD_W-1] = code[WORD_W-1] ^ twos;
        return r;
    endfunction

endpackage

// File: rtl/dsd_edge_capture.sv
module dsd_edge_capture
    import dsd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,   // must be at least 2
    parameter int CAP_DELAY   = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     conv_clk_i,
    input  word_t    conv_bus_i,
    input  logic     chan_a_i,
    output capture_t cap_o
);

    localparam int DLY_W = (CAP_DELAY > 0) ? $clog2(CAP_DELAY + 1) : 1;
    localparam int LAST  = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0]             clk_sh;
        logic [SYNC_STAGES-1:0]             ind_sh;
        logic [SYNC_STAGES-1:0][WORD_W-1:0] bus_sh;
        logic                               clk_prev;
        logic                               pending;
        logic                               pend_rise;
        logic [DLY_W-1:0]                   dly;
        capture_t                           cap;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        // synchronizer chains
        st_d.clk_sh[0] = conv_clk_i;
        st_d.ind_sh[0] = chan_a_i;
        st_d.bus_sh[0] = conv_bus_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.clk_sh[i] = st_q.clk_sh[i-1];
            st_d.ind_sh[i] = st_q.ind_sh[i-1];
            st_d.bus_sh[i] = st_q.bus_sh[i-1];
        end
        st_d.clk_prev = st_q.clk_sh[LAST];

        st_d.cap.fire = 1'b0;

        if (st_q.clk_sh[LAST] != st_q.clk_prev) begin
            // edge seen: arm the phase-offset timer
            st_d.pending   = 1'b1;
            st_d.pend_rise = st_q.clk_sh[LAST];
            st_d.dly       = DLY_W'(CAP_DELAY);
        end else if (st_q.pending) begin
            if (st_q.dly == '0) begin
                st_d.pending   = 1'b0;
                st_d.cap.fire  = 1'b1;
                st_d.cap.rise  = st_q.pend_rise;
                st_d.cap.ind   = st_q.ind_sh[LAST];
                st_d.cap.word  = st_q.bus_sh[LAST];
            end else begin
                st_d.dly = st_q.dly - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_o = st_q.cap;

endmodule

// File: rtl/dsd_pair_assembler.sv
module dsd_pair_assembler
    import dsd_pkg::*;
#(
    parameter int IDX_W          = 8,
    parameter int LATENCY_CYCLES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  capture_t         cap_i,
    input  logic             twos_comp_i,
    output logic             pair_valid_o,
    output word_t            pair_a_o,
    output word_t            pair_b_o,
    output logic [IDX_W-1:0] pair_tag_o,
    output logic             misalign_o
);

    localparam logic [IDX_W-1:0] LAT_TAG = IDX_W'(LATENCY_CYCLES);

    typedef struct packed {
        pair_st_e         st;
        word_t            held_a;
        logic [IDX_W-1:0] held_tag;
        logic [IDX_W-1:0] rise_cnt;
        logic             valid;
        word_t            out_a;
        word_t            out_b;
        logic [IDX_W-1:0] out_tag;
        logic             err;
    } asm_state_t;

    asm_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;

        if (cap_i.fire) begin
            if (cap_i.rise) begin
                st_d.rise_cnt = st_q.rise_cnt + 1'b1;
                if (cap_i.ind) begin
                    st_d.st       = ST_HOLD_A;
                    st_d.held_a   = cap_i.word;
                    st_d.held_tag = st_q.rise_cnt - LAT_TAG;
                end else begin
                    st_d.err = 1'b1;
                    st_d.st  = ST_WAIT_A;
                end
            end else begin
                if (cap_i.ind) begin
                    st_d.err = 1'b1;
                    st_d.st  = ST_WAIT_A;
                end else if (st_q.st == ST_HOLD_A) begin
                    st_d.valid   = 1'b1;
                    st_d.out_a   = fmt_word(st_q.held_a, twos_comp_i);
                    st_d.out_b   = fmt_word(cap_i.word, twos_comp_i);
                    st_d.out_tag = st_q.held_tag;
                    st_d.st      = ST_WAIT_A;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pair_valid_o = st_q.valid;
    assign pair_a_o     = st_q.out_a;
    assign pair_b_o     = st_q.out_b;
    assign pair_tag_o   = st_q.out_tag;
    assign misalign_o   = st_q.err;

endmodule

// File: rtl/dual_sample_demux.sv
module dual_sample_demux
    import dsd_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int CAP_DELAY      = 2,
    parameter int IDX_W          = 8,
    parameter int LATENCY_CYCLES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_clk_i,
    input  logic [7:0]       conv_bus_i,
    input  logic             chan_a_i,
    input  logic             twos_comp_i,
    output logic             pair_valid_o,
    output logic [7:0]       pair_a_o,
    output logic [7:0]       pair_b_o,
    output logic [IDX_W-1:0] pair_tag_o,
    output logic             misalign_o
);

    capture_t cap;

    dsd_edge_capture #(
        .SYNC_STAGES (SYNC_STAGES),
        .CAP_DELAY   (CAP_DELAY)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_clk_i (conv_clk_i),
        .conv_bus_i (conv_bus_i),
        .chan_a_i   (chan_a_i),
        .cap_o      (cap)
    );

    dsd_pair_assembler #(
        .IDX_W          (IDX_W),
        .LATENCY_CYCLES (LATENCY_CYCLES)
    ) u_assembler (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_i        (cap),
        .twos_comp_i  (twos_comp_i),
        .pair_valid_o (pair_valid_o),
        .pair_a_o     (pair_a_o),
        .pair_b_o     (pair_b_o),
        .pair_tag_o   (pair_tag_o),
        .misalign_o   (misalign_o)
    );

endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pair_valid_o,
    input logic [7:0]       pair_a_o,
    input logic [7:0]       pair_b_o,
    input logic [IDX_W-1:0] pair_tag_o,
    input logic             misalign_o
);

    // R1: outputs quiet while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_reset_quiet_r1: assert (!pair_valid_o && !misalign_o &&
                                      pair_a_o == 8'h00 && pair_b_o == 8'h00)
                else $error("R1 outputs not quiet in reset");
        end
    end

    // R2: a pair strobe lasts one cycle
    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |=> !pair_valid_o)
        else $error("R2 valid longer than one cycle");

    // R2: presented pair only changes together with a strobe
    p_pair_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid_o |-> $stable(pair_a_o) && $stable(pair_b_o))
        else $error("R2 pair changed without strobe");

    // R3: tag only changes with a strobe
    p_tag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid_o |-> $stable(pair_tag_o))
        else $error("R3 tag changed without strobe");

    // R8: misalignment flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |=> misalign_o)
        else $error("R8 misalign flag cleared");

endmodule

bind dual_sample_demux dsd_checker #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pair_valid_o (pair_valid_o),
    .pair_a_o     (pair_a_o),
    .pair_b_o     (pair_b_o),
    .pair_tag_o   (pair_tag_o),
    .misalign_o   (misalign_o)
);

// File: tb/dual_sample_demux_tb.sv
`timescale 1ns/1ps
module dual_sample_demux_tb;

    localparam int IDX_W = 8;

    typedef struct {
        logic [7:0]       a;
        logic [7:0]       b;
        logic [IDX_W-1:0] tag;
    } pair_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             conv_clk = 1'b0;
    logic [7:0]       bus = 8'h00;
    logic             chan = 1'b0;
    logic             twos = 1'b0;
    logic             pair_valid;
    logic [7:0]       pair_a, pair_b;
    logic [IDX_W-1:0] pair_tag;
    logic             misalign;

    int    checks = 0;
    int    errors = 0;
    int    n_rise = 0;
    int    pushed = 0;
    int    got = 0;
    bit    done = 1'b0;
    bit    prev_valid = 1'b0;
    pair_t exp_q[$];

    always #5 clk = ~clk;

    dual_sample_demux #(.IDX_W(IDX_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_clk_i   (conv_clk),
        .conv_bus_i   (bus),
        .chan_a_i     (chan),
        .twos_comp_i  (twos),
        .pair_valid_o (pair_valid),
        .pair_a_o     (pair_a),
        .pair_b_o     (pair_b),
        .pair_tag_o   (pair_tag),
        .misalign_o   (misalign)
    );

    function automatic logic [7:0] exp_fmt(input logic [7:0] w, input logic t);
        return t ? {~w[7], w[6:0]} : w;
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // monitor: compare every strobe with the model queue
    always @(negedge clk) begin
        if (rst_n && pair_valid) begin
            pair_t e;
            got++;
            check(!prev_valid, "R2 strobe longer than one cycle", 1, 0);
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected pair", int'(pair_a), -1);
            end else begin
                e = exp_q.pop_front();
                check(pair_a == e.a, "R2 R4 R5 channel A word", int'(pair_a), int'(e.a));
                check(pair_b == e.b, "R2 R4 R5 channel B word", int'(pair_b), int'(e.b));
                check(pair_tag == e.tag, "R3 pair tag", int'(pair_tag), int'(e.tag));
            end
        end
        prev_valid = rst_n && pair_valid;
    end

    // one converter period: rise carries A, fall carries B, 6 ns after each edge (R9)
    task automatic conv_cycle(input logic [7:0] aw, input logic [7:0] bw,
                              input bit bad_r, input bit bad_f);
        pair_t e;
        conv_clk = 1'b1;
        #6;
        bus  = aw;
        chan = !bad_r;
        #74;
        conv_clk = 1'b0;
        #6;
        bus  = bw;
        chan = bad_f;
        if (!bad_r && !bad_f) begin
            e.a   = exp_fmt(aw, twos);
            e.b   = exp_fmt(bw, twos);
            e.tag = IDX_W'(n_rise - 5);
            exp_q.push_back(e);
            pushed++;
        end
        n_rise++;
        #74;
    endtask

    task automatic drain();
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R2 pairs missing", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        conv_clk = 1'b0;
        chan = 1'b0;
        n_rise = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!pair_valid && !misalign && pair_a == 8'h00 && pair_b == 8'h00 &&
              pair_tag == '0, "R1 reset state", int'({pair_valid, misalign}), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(!pair_valid && !misalign, "R1 after reset release", int'({pair_valid, misalign}), 0);
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        do_reset();

        // random traffic, offset binary (R2, R3, R4, R9)
        twos = 1'b0;
        for (int i = 0; i < 120; i++) conv_cycle(8'($urandom), 8'($urandom), 1'b0, 1'b0);
        drain();

        // directed corners, offset binary (R4)
        conv_cycle(8'h80, 8'h00, 1'b0, 1'b0);
        drain();
        check(pair_a == 8'h80, "R4 mid-scale passthrough", int'(pair_a), 'h80);
        check(pair_b == 8'h00, "R4 zero passthrough", int'(pair_b), 'h00);

        // two's complement (R5)
        twos = 1'b1;
        conv_cycle(8'h80, 8'h00, 1'b0, 1'b0);
        drain();
        check(pair_a == 8'h00, "R5 mid-scale to zero", int'(pair_a), 'h00);
        check(pair_b == 8'h80, "R5 zero to most negative", int'(pair_b), 'h80);
        conv_cycle(8'hFF, 8'h7F, 1'b0, 1'b0);
        drain();
        check(pair_a == 8'h7F, "R5 full scale", int'(pair_a), 'h7F);
        check(pair_b == 8'hFF, "R5 below mid-scale", int'(pair_b), 'hFF);
        for (int i = 0; i < 60; i++) conv_cycle(8'($urandom), 8'($urandom), 1'b0, 1'b0);
        drain();
        check(!misalign, "R6 no flag on clean traffic", int'(misalign), 0);

        // wrong indicator at rise (R6), tags continue across gap (R3)
        conv_cycle(8'h11, 8'h22, 1'b1, 1'b0);
        drain();
        check(misalign, "R6 flag after bad rise", int'(misalign), 1);
        for (int i = 0; i < 20; i++) conv_cycle(8'($urandom), 8'($urandom), 1'b0, 1'b0);
        drain();
        check(misalign, "R8 flag held through clean traffic", int'(misalign), 1);

        // reset clears, then wrong indicator at fall (R7)
        twos = 1'b0;
        do_reset();
        for (int i = 0; i < 10; i++) conv_cycle(8'($urandom), 8'($urandom), 1'b0, 1'b0);
        drain();
        check(!misalign, "R8 flag cleared by reset", int'(misalign), 0);
        conv_cycle(8'h33, 8'h44, 1'b0, 1'b1);
        drain();
        check(misalign, "R7 flag after bad fall", int'(misalign), 1);
        conv_cycle(8'h55, 8'h66, 1'b0, 1'b0);
        drain();
        check(pair_a == 8'h55 && pair_b == 8'h66, "R7 resumes with next good pair",
              int'({pair_a, pair_b}), 'h5566);
        for (int i = 0; i < 20; i++) conv_cycle(8'($urandom), 8'($urandom), 1'b0, 1'b0);
        drain();
        check(misalign, "R8 flag still set", int'(misalign), 1);
        check(got == pushed, "R2 pair count", got, pushed);

        done = 1'b1;
        finish_run();
    end

endmodule